// File: doc/BRIEF.md
# PS/2 Device-to-Host Frame Receiver

This block takes the two open-collector lines of a PS/2 keyboard or mouse port, which rest high whenever no transfer is under way, and turns the serial traffic sent by the device into bytes in the system clock domain. Both lines pass through a two-flop synchronizer. The device clock then goes through a stability filter, so a slow or noisy edge counts only once. A bit is taken on every falling edge of the filtered device clock.

A frame is eleven bits long: a start bit, then eight data bits with the least significant bit first, then an odd-parity bit, then a stop bit. When the eleventh bit arrives, the block checks the frame. A well-formed frame produces a one-cycle byte strobe, together with a flag that reports a bad parity. If the start bit or the stop bit is wrong, the frame is dropped and a one-cycle framing flag is raised instead. A frame that stops partway through is abandoned after an idle interval with no clock edges, so the next frame is received aligned.

Top module: `ps2_rx_frame`

## Requirements
- R1: During and right after reset, `byte_valid_o`, `parity_err_o`, `frame_err_o` and `byte_o` are all 0, and the receiver waits for a start bit.
- R2: The bit on the data line is taken at each falling edge of the filtered device clock. Bit 0 of a frame is the start bit, bits 1 to 8 carry `byte_o[0]` to `byte_o[7]`, bit 9 is parity and bit 10 is the stop bit. The byte is presented one cycle after the falling edge of bit 10.
- R3: `byte_valid_o` is high for exactly one system clock cycle per accepted frame.
- R4: `parity_err_o` is high in the same cycle as `byte_valid_o` when the eight data bits plus the parity bit hold an even number of ones. It is low when they hold an odd number, and it is never high without `byte_valid_o`.
- R5: A frame whose start bit is 1 produces no byte strobe and a one-cycle `frame_err_o` pulse.
- R6: A frame whose stop bit is 0 produces no byte strobe and a one-cycle `frame_err_o` pulse.
- R7: A low excursion of the device clock that lasts fewer than `FILTER_LEN` system cycles is ignored and does not count as a bit. The filtered clock changes only after the synchronized clock has held its new level.
- R8: If a frame is in progress and no falling device-clock edge comes for `TIMEOUT_CYCLES` cycles, the bit count returns to idle, and the next frame is received correctly.
- R9: A pause between device-clock edges shorter than `TIMEOUT_CYCLES` cycles does not abort the frame.
- R10: `byte_valid_o` and `frame_err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_i | input | 1 | Device clock line, asynchronous, idles high |
| ps2_dat_i | input | 1 | Device data line, asynchronous, idles high |
| byte_o | output | 8 | Last received data byte |
| byte_valid_o | output | 1 | One-cycle strobe for a well-framed byte |
| parity_err_o | output | 1 | Parity failure, valid alongside `byte_valid_o` |
| frame_err_o | output | 1 | One-cycle pulse for a dropped frame (bad start or stop bit) |

## Verification
The bench sends random bytes, and one frame in four carries a corrupted parity bit. This catches a receiver that assembles bits in the wrong order, which would return bit-reversed bytes, and one that checks even parity, which would flag every good frame. Frames with a bad start bit or a bad stop bit must produce a framing pulse and no byte. A design that skips either check would hand over garbage as valid data. Two-cycle glitches placed inside the clock-high phase would shift every later bit by one in a design without a working filter. A partial frame followed by a long idle gap shows whether the timeout realigns the receiver; a missing timeout corrupts the next frame. A long gap that stays under the limit shows that the timeout does not fire too early.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

    localparam int FRAME_LEN = 11;
    localparam int DATA_W    = 8;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    typedef logic [IDX_W-1:0]     bit_idx_t;
    typedef logic [FRAME_LEN-1:0] frame_bits_t;

    localparam bit_idx_t LAST_IDX = bit_idx_t'(FRAME_LEN - 1);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              parity_bad;
        logic              framing_bad;
    } ps2_word_t;

    // frame layout: [0] start, [8:1] data lsb first, [9] parity, [10] stop
    function automatic ps2_word_t decode_frame(input frame_bits_t f);
        ps2_word_t w;
        w.data        = f[DATA_W:1];
        w.parity_bad  = ~(^f[DATA_W+1:1]);
        w.framing_bad = f[0] | ~f[FRAME_LEN-1];
        return w;
    endfunction

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= IDLE_VAL;
                    else     chain[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= IDLE_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/ps2_glitch_filter.sv
module ps2_glitch_filter #(
    parameter int FILTER_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    output logic filt_o,
    output logic fall_o
);
    localparam int CW = $clog2(FILTER_LEN + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(FILTER_LEN - 1);

    logic [CW-1:0] run_cnt;
    logic          level;
    logic          level_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            level   <= 1'b1;
        end else if (sync_i == level) begin
            run_cnt <= '0;
        end else if (run_cnt == CNT_TOP) begin
            run_cnt <= '0;
            level   <= sync_i;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) level_d <= 1'b1;
        else     level_d <= level;
    end

    assign filt_o = level;
    assign fall_o = level_d & ~level;
endmodule

// File: rtl/ps2_idle_timer.sv
module ps2_idle_timer #(
    parameter int TIMEOUT_CYCLES = 12500
) (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    input  logic edge_i,
    output logic expire_o
);
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYCLES - 1);

    logic [TW-1:0] quiet_cnt;

    assign expire_o = busy_i && !edge_i && (quiet_cnt == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || !busy_i || edge_i || expire_o) quiet_cnt <= '0;
        else                                       quiet_cnt <= quiet_cnt + 1'b1;
    end
endmodule

// File: rtl/ps2_frame_shift.sv
module ps2_frame_shift
    import ps2_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fall_i,
    input  logic                 dat_i,
    input  logic                 abort_i,
    output logic                 busy_o,
    output bit_idx_t             idx_o,
    output logic [DATA_W-1:0]    byte_o,
    output logic                 valid_o,
    output logic                 perr_o,
    output logic                 ferr_o
);
    frame_bits_t shreg;
    frame_bits_t shreg_nxt;
    bit_idx_t    idx;
    ps2_word_t   word;
    logic        frame_done;

    assign shreg_nxt  = {dat_i, shreg[FRAME_LEN-1:1]};
    assign word       = decode_frame(shreg_nxt);
    assign frame_done = fall_i && (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
            idx   <= '0;
        end else if (fall_i) begin
            shreg <= shreg_nxt;
            idx   <= frame_done ? '0 : idx + 1'b1;
        end else if (abort_i) begin
            idx   <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_o  <= '0;
            valid_o <= 1'b0;
            perr_o  <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= frame_done && !word.framing_bad;
            perr_o  <= frame_done && !word.framing_bad && word.parity_bad;
            ferr_o  <= frame_done && word.framing_bad;
            if (frame_done && !word.framing_bad) byte_o <= word.data;
        end
    end

    assign busy_o = (idx != '0);
    assign idx_o  = idx;
endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame
    import ps2_rx_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int FILTER_LEN     = 4,
    parameter int TIMEOUT_CYCLES = 12500
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ps2_clk_i,
    input  logic        ps2_dat_i,
    output logic [7:0]  byte_o,
    output logic        byte_valid_o,
    output logic        parity_err_o,
    output logic        frame_err_o
);
    logic     sync_clk;
    logic     sync_dat;
    logic     filt_clk;
    logic     clk_fall;
    logic     busy;
    logic     tmo_hit;
    bit_idx_t bit_cnt;

    ps2_line_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync_clk (
        .clk(clk), .rst(rst), .async_i(ps2_clk_i), .sync_o(sync_clk)
    );

    ps2_line_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync_dat (
        .clk(clk), .rst(rst), .async_i(ps2_dat_i), .sync_o(sync_dat)
    );

    ps2_glitch_filter #(.FILTER_LEN(FILTER_LEN)) u_filter (
        .clk(clk), .rst(rst), .sync_i(sync_clk), .filt_o(filt_clk), .fall_o(clk_fall)
    );

    ps2_idle_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .busy_i(busy), .edge_i(clk_fall), .expire_o(tmo_hit)
    );

    ps2_frame_shift u_shift (
        .clk(clk), .rst(rst), .fall_i(clk_fall), .dat_i(sync_dat), .abort_i(tmo_hit),
        .busy_o(busy), .idx_o(bit_cnt), .byte_o(byte_o), .valid_o(byte_valid_o),
        .perr_o(parity_err_o), .ferr_o(frame_err_o)
    );
endmodule

// File: rtl/ps2_rx_checker.sv
module ps2_rx_checker
    import ps2_rx_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     byte_valid_o,
    input logic     parity_err_o,
    input logic     frame_err_o,
    input logic     clk_fall,
    input logic     tmo_hit,
    input logic     filt_clk,
    input logic     sync_clk,
    input bit_idx_t bit_cnt
);
    p_strobe_after_edge_r2: assert property (@(posedge clk) disable iff (rst)
        (byte_valid_o || frame_err_o) |-> $past(clk_fall));

    p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |=> !byte_valid_o);

    p_perr_needs_valid_r4: assert property (@(posedge clk) disable iff (rst)
        parity_err_o |-> byte_valid_o);

    p_single_ferr_r5: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |=> !frame_err_o);

    p_filter_follows_r7: assert property (@(posedge clk) disable iff (rst)
        (filt_clk != $past(filt_clk)) |-> ($past(sync_clk) == filt_clk));

    p_timeout_idle_r8: assert property (@(posedge clk) disable iff (rst)
        tmo_hit |=> (bit_cnt == '0));

    p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(byte_valid_o && frame_err_o));
endmodule

bind ps2_rx_frame ps2_rx_checker u_chk (
    .clk(clk), .rst(rst), .byte_valid_o(byte_valid_o), .parity_err_o(parity_err_o),
    .frame_err_o(frame_err_o), .clk_fall(clk_fall), .tmo_hit(tmo_hit),
    .filt_clk(filt_clk), .sync_clk(sync_clk), .bit_cnt(bit_cnt)
);

// File: tb/ps2_rx_frame_bench.sv
`timescale 1ns/1ps
module ps2_rx_frame_bench;
    localparam int HALF    = 20;
    localparam int TMO     = 200;
    localparam int FLT     = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ps2_clk = 1'b1;
    logic       ps2_dat = 1'b1;
    logic [7:0] byte_o;
    logic       byte_valid_o, parity_err_o, frame_err_o;

    int total = 0;
    int bad   = 0;
    int n_valid = 0, n_ferr = 0, n_wide = 0;
    logic [7:0] cap_byte = '0;
    logic       cap_perr = 1'b0;
    logic       prev_v = 1'b0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    ps2_rx_frame #(.FILTER_LEN(FLT), .TIMEOUT_CYCLES(TMO)) u_ps2_rx_frame (
        .clk(clk), .rst(rst), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
        .byte_o(byte_o), .byte_valid_o(byte_valid_o),
        .parity_err_o(parity_err_o), .frame_err_o(frame_err_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid_o) begin
                n_valid++;
                cap_byte = byte_o;
                cap_perr = parity_err_o;
                if (prev_v) n_wide++;
            end
            if (frame_err_o) n_ferr++;
            prev_v = byte_valid_o;
        end
    end

    function automatic logic odd_par(input logic [7:0] d);
        return ~(^d);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    // send nbits of a frame; glitch_at>=0 inserts a short clock dip in that bit's high phase
    task automatic send(input logic [7:0] d, input logic par, input logic st,
                        input logic sp, input int nbits, input int glitch_at, input int gap_at);
        logic [10:0] f;
        f = {sp, par, d, st};
        for (int i = 0; i < nbits; i++) begin
            @(posedge clk); #1;
            ps2_dat = f[i];
            wait_cyc(HALF);
            if (i == glitch_at) begin
                #1 ps2_clk = 1'b0;
                wait_cyc(FLT - 2);
                #1 ps2_clk = 1'b1;
                wait_cyc(HALF);
            end
            if (i == gap_at) wait_cyc(TMO / 2);
            #1 ps2_clk = 1'b0;
            wait_cyc(HALF);
            #1 ps2_clk = 1'b1;
        end
        wait_cyc(HALF);
        #1 ps2_dat = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic good_frame(input logic [7:0] d, input string req);
        int v0;
        v0 = n_valid;
        send(d, odd_par(d), 1'b0, 1'b1, 11, -1, -1);
        chk(n_valid == v0 + 1, req, n_valid - v0, 1);
        chk(cap_byte == d, req, cap_byte, d);
        chk(cap_perr == 1'b0, req, cap_perr, 0);
    endtask

    initial begin
        int v0, f0;
        logic [7:0] d;
        logic       corrupt;
        void'($urandom(32'h5EED_0042));
        wait_cyc(5);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(byte_valid_o == 0 && parity_err_o == 0 && frame_err_o == 0, "R1 flags", 
            {byte_valid_o, parity_err_o, frame_err_o}, 0);
        chk(byte_o == 8'h00, "R1 byte", byte_o, 0);

        // R2: lsb-first directed patterns
        good_frame(8'h01, "R2 lsb");
        good_frame(8'h80, "R2 msb");
        good_frame(8'hA5, "R2 mix");

        // R3: no strobe ever wider than one cycle (checked at end) and R4 parity corner
        v0 = n_valid;
        send(8'h00, 1'b0, 1'b0, 1'b1, 11, -1, -1);
        chk(n_valid == v0 + 1 && cap_perr == 1'b1, "R4 even ones", cap_perr, 1);
        good_frame(8'hFF, "R4 all ones");

        // R5: bad start bit
        v0 = n_valid; f0 = n_ferr;
        send(8'h3C, odd_par(8'h3C), 1'b1, 1'b1, 11, -1, -1);
        chk(n_valid == v0, "R5 no byte", n_valid - v0, 0);
        chk(n_ferr == f0 + 1, "R5 ferr", n_ferr - f0, 1);
        chk(byte_o == 8'hFF, "R5 byte kept", byte_o, 8'hFF);

        // R6: bad stop bit
        v0 = n_valid; f0 = n_ferr;
        send(8'hC3, odd_par(8'hC3), 1'b0, 1'b0, 11, -1, -1);
        chk(n_valid == v0, "R6 no byte", n_valid - v0, 0);
        chk(n_ferr == f0 + 1, "R6 ferr", n_ferr - f0, 1);

        // R7: glitches inside the clock-high phase
        v0 = n_valid;
        send(8'h5A, odd_par(8'h5A), 1'b0, 1'b1, 11, 3, -1);
        chk(n_valid == v0 + 1 && cap_byte == 8'h5A, "R7 glitch mid", cap_byte, 8'h5A);
        v0 = n_valid;
        send(8'h96, odd_par(8'h96), 1'b0, 1'b1, 11, 9, -1);
        chk(n_valid == v0 + 1 && cap_byte == 8'h96, "R7 glitch parity", cap_byte, 8'h96);

        // R8: partial frame, long idle, then a full frame
        v0 = n_valid; f0 = n_ferr;
        send(8'h0F, 1'b1, 1'b0, 1'b1, 5, -1, -1);
        wait_cyc(2 * TMO);
        chk(n_valid == v0 && n_ferr == f0, "R8 partial silent", n_valid - v0, 0);
        good_frame(8'h6E, "R8 realign");

        // R9: pause below the timeout in the middle of a frame
        v0 = n_valid;
        send(8'hB1, odd_par(8'hB1), 1'b0, 1'b1, 11, -1, 4);
        chk(n_valid == v0 + 1 && cap_byte == 8'hB1, "R9 gap kept", cap_byte, 8'hB1);

        // R2/R4 random frames with some parity corruption
        for (int k = 0; k < 30; k++) begin
            d = 8'($urandom);
            corrupt = ($urandom % 4) == 0;
            v0 = n_valid;
            send(d, odd_par(d) ^ corrupt, 1'b0, 1'b1, 11, -1, -1);
            chk(n_valid == v0 + 1 && cap_byte == d, "R2 random byte", cap_byte, d);
            chk(cap_perr == corrupt, "R4 random parity", cap_perr, corrupt);
            wait_cyc($urandom % 40);
        end

        chk(n_wide == 0, "R3 strobe width", n_wide, 0);
        // R10 exclusivity is also watched per cycle by the bound checker
        chk(!(byte_valid_o && frame_err_o), "R10 exclusive", {byte_valid_o, frame_err_o}, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule